// File: doc/BRIEF.md
# Direct-Matching Operand Synchronization Unit

This block decides when a dataflow instruction may fire. Each incoming token carries one data operand, an operand segment number, a displacement and a two-bit synchronization flag. Single-operand tokens fire at once. Two-operand tokens meet in an operand memory that is addressed directly by joining the segment number and the displacement. No associative search is made: one presence bit per slot is tested and then set or cleared. When a fire happens, the unit sends out a packet. The packet holds the instruction address, built from the segment's template base joined with the same displacement, and the two operands in left/right order.

A small table maps each operand segment to its template segment number, and plain write pins load it. In thread mode, a token marked as the first instruction of a thread locks the token input once it fires. The lock holds until the execution side pulses a completion signal, so that the thread's instructions can issue back to back.

Tokens enter on a valid/ready stream and fire packets leave on one. A token is taken on a clock edge where both `tok_valid` and `tok_ready` are high. `tok_ready` is low while the presence bits are being swept after reset, while a thread lock is held, and while a fire packet is waiting with `fire_ready` low. A waiting fire packet holds all its fields until it is taken.

Top module: `dm_sync_unit`

## Requirements
- R1: After reset deasserts, `tok_ready` stays low for at least 2^(SEG_W+DISP_W) cycles while every presence bit is cleared. During that time `fire_valid` is low.
- R2: A token with flag 00 (monadic) that is taken produces a fire packet in the next cycle. The packet has `fire_left` equal to the token data, `fire_right` equal to zero, and `fire_flag` equal to 00.
- R3: A token with flag 11 (immediate) fires in the same way as R2 with `fire_flag` 11, and it neither reads nor changes the presence bit or stored operand of its slot.
- R4: `fire_addr` is the template segment number stored for the token's segment, as the upper bits, joined with the token's displacement, as the lower DISP_W bits. A write with `tmpl_we` high changes the entry for `tmpl_wseg` from the next cycle on.
- R5: A two-operand token (flag 01 left, 10 right) that finds its slot's presence bit clear stores its data, sets the bit and produces no fire packet. One that finds the bit set produces a fire packet in the next cycle.
- R6: On a two-operand fire, the arriving token's data is placed on the side its own flag names, and the stored partner is placed on the other side. `fire_flag` echoes the arriving flag.
- R7: A two-operand fire clears the slot's presence bit, so the next two-operand token to that slot is stored again. Slots that differ only in segment number never match each other.
- R8: Two tokens to the same slot taken on consecutive clock edges match correctly: the second one sees the first one's store.
- R9: While `fire_valid` is high and `fire_ready` is low, all fire fields hold their values and `tok_ready` is low.
- R10: With `thread_mode` high, a fire of a token with `tok_first` high drives `tok_ready` low until a cycle with `thread_done` high. With `thread_mode` low, `tok_first` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmpl_we | input | 1 | Template table write enable |
| tmpl_wseg | input | SEG_W | Operand segment whose template entry is written |
| tmpl_wval | input | TSEG_W | Template segment number to store |
| thread_mode | input | 1 | Enables the thread lock |
| thread_done | input | 1 | Pulse that releases the thread lock |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Unit can take a token this cycle |
| tok_data | input | DATA_W | Token operand |
| tok_seg | input | SEG_W | Operand segment number |
| tok_disp | input | DISP_W | Displacement |
| tok_flag | input | 2 | 00 monadic, 01 left, 10 right, 11 immediate |
| tok_first | input | 1 | Token is the first instruction of a thread |
| fire_valid | output | 1 | Fire packet present |
| fire_ready | input | 1 | Consumer takes the fire packet |
| fire_addr | output | TSEG_W+DISP_W | Instruction address |
| fire_left | output | DATA_W | Left operand |
| fire_right | output | DATA_W | Right operand |
| fire_flag | output | 2 | Flag of the token that caused the fire |

## Verification
A presence bit left in the wrong state shows up at the ports on the next token to that slot. A bit that is wrongly set causes a fire one token too early, with a stale partner. A bit that is wrongly clear causes a missing fire, and the stream stays silent where a packet was due. Operand order, address joining and the template lookup appear in the first fire packet after the token is taken. A lock that is stuck, or a sweep that never ends, shows up as `tok_ready` staying low past the cycle where it should rise. The directed tests therefore go back to slots they have already used, and they watch `tok_ready` during each cycle that matters.

// File: rtl/dm_sync_pkg.sv
package dm_sync_pkg;
  typedef enum logic [1:0] {
    FLG_MONO  = 2'b00,
    FLG_LEFT  = 2'b01,
    FLG_RIGHT = 2'b10,
    FLG_IMM   = 2'b11
  } sync_flag_e;

  function automatic logic is_pair(input logic [1:0] f);
    return (f == FLG_LEFT) || (f == FLG_RIGHT);
  endfunction
endpackage

// File: rtl/dm_tmpl_table.sv
module dm_tmpl_table #(
  parameter int SEG_W  = 3,
  parameter int TSEG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEG_W-1:0]  wseg,
  input  logic [TSEG_W-1:0] wval,
  input  logic [SEG_W-1:0]  rseg,
  output logic [TSEG_W-1:0] rval
);
  localparam int SEGS = 1 << SEG_W;

  logic [TSEG_W-1:0] entry [SEGS];

  for (genvar g = 0; g < SEGS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) entry[g] <= '0;
      else if (we && wseg == SEG_W'(g)) entry[g] <= wval;
    end
  end

  assign rval = entry[rseg];
endmodule

// File: rtl/dm_operand_store.sv
module dm_operand_store #(
  parameter int DATA_W = 16,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              pres_q,
  output logic [DATA_W-1:0] rdata,
  output logic              ready
);
  localparam int SLOTS = 1 << AW;

  logic [SLOTS-1:0]  pres;
  logic [DATA_W-1:0] mem [SLOTS];
  logic [AW-1:0]     sweep_cnt;
  logic              sweeping;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sweeping  <= 1'b1;
      sweep_cnt <= '0;
    end else if (sweeping) begin
      sweep_cnt <= sweep_cnt + 1'b1;
      if (sweep_cnt == AW'(SLOTS - 1)) sweeping <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (sweeping) pres[sweep_cnt] <= 1'b0;
    else if (set_en) pres[addr] <= 1'b1;
    else if (clr_en) pres[addr] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (set_en) mem[addr] <= wdata;
  end

  // Flop-array read is combinational, so a write on one edge is seen by
  // the token taken on the very next edge.
  assign pres_q = pres[addr];
  assign rdata  = mem[addr];
  assign ready  = !sweeping;

  // R1
  sweep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |-> !set_en && !clr_en);
  // R5
  store_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !pres[addr]);
  // R7
  clear_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> pres[addr]);
endmodule

// File: rtl/dm_thread_gate.sv
module dm_thread_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_set,
  input  logic release_i,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (!rst_n) locked <= 1'b0;
    else if (lock_set) locked <= 1'b1;
    else if (release_i) locked <= 1'b0;
  end
endmodule

// File: rtl/dm_sync_unit.sv
module dm_sync_unit
  import dm_sync_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEG_W  = 3,
  parameter int DISP_W = 4,
  parameter int TSEG_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tmpl_we,
  input  logic [SEG_W-1:0]         tmpl_wseg,
  input  logic [TSEG_W-1:0]        tmpl_wval,
  input  logic                     thread_mode,
  input  logic                     thread_done,
  input  logic                     tok_valid,
  output logic                     tok_ready,
  input  logic [DATA_W-1:0]        tok_data,
  input  logic [SEG_W-1:0]         tok_seg,
  input  logic [DISP_W-1:0]        tok_disp,
  input  logic [1:0]               tok_flag,
  input  logic                     tok_first,
  output logic                     fire_valid,
  input  logic                     fire_ready,
  output logic [TSEG_W+DISP_W-1:0] fire_addr,
  output logic [DATA_W-1:0]        fire_left,
  output logic [DATA_W-1:0]        fire_right,
  output logic [1:0]               fire_flag
);
  localparam int MAW = SEG_W + DISP_W;
  localparam int IAW = TSEG_W + DISP_W;

  logic              accept, pair, hit, do_fire, st_set, st_clr;
  logic              store_ready, locked;
  logic [MAW-1:0]    match_addr;
  logic [TSEG_W-1:0] tseg;
  logic [DATA_W-1:0] partner;
  logic [DATA_W-1:0] nxt_left, nxt_right;

  assign match_addr = {tok_seg, tok_disp};
  assign tok_ready  = store_ready && !locked && (!fire_valid || fire_ready);
  assign accept     = tok_valid && tok_ready;
  assign pair       = is_pair(tok_flag);
  assign do_fire    = accept && (!pair || hit);
  assign st_set     = accept && pair && !hit;
  assign st_clr     = accept && pair && hit;

  dm_tmpl_table #(.SEG_W(SEG_W), .TSEG_W(TSEG_W)) tmpl_i (
    .clk(clk), .rst_n(rst_n), .we(tmpl_we), .wseg(tmpl_wseg),
    .wval(tmpl_wval), .rseg(tok_seg), .rval(tseg)
  );

  dm_operand_store #(.DATA_W(DATA_W), .AW(MAW)) store_i (
    .clk(clk), .rst_n(rst_n), .addr(match_addr), .set_en(st_set),
    .clr_en(st_clr), .wdata(tok_data), .pres_q(hit), .rdata(partner),
    .ready(store_ready)
  );

  dm_thread_gate gate_i (
    .clk(clk), .rst_n(rst_n),
    .lock_set(do_fire && thread_mode && tok_first),
    .release_i(thread_done), .locked(locked)
  );

  always_comb begin
    unique case (tok_flag)
      FLG_LEFT:  begin nxt_left = tok_data; nxt_right = partner;  end
      FLG_RIGHT: begin nxt_left = partner;  nxt_right = tok_data; end
      default:   begin nxt_left = tok_data; nxt_right = '0;       end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fire_valid <= 1'b0;
      fire_addr  <= '0;
      fire_left  <= '0;
      fire_right <= '0;
      fire_flag  <= FLG_MONO;
    end else if (do_fire) begin
      fire_valid <= 1'b1;
      fire_addr  <= IAW'({tseg, tok_disp});
      fire_left  <= nxt_left;
      fire_right <= nxt_right;
      fire_flag  <= tok_flag;
    end else if (fire_ready) begin
      fire_valid <= 1'b0;
    end
  end

  // R9
  fire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_valid && !fire_ready |=> fire_valid && $stable(fire_left)
      && $stable(fire_right) && $stable(fire_addr) && $stable(fire_flag));
  // R10
  lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !accept);
  // R1
  sweep_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !store_ready |-> !fire_valid);
endmodule

// File: tb/dm_sync_unit_tb_top.sv
module dm_sync_unit_tb_top;
  localparam int DATA_W = 16;
  localparam int SEG_W  = 3;
  localparam int DISP_W = 4;
  localparam int TSEG_W = 4;
  localparam int SLOTS  = 1 << (SEG_W + DISP_W);

  logic clk = 0, rst_n = 0;
  logic tmpl_we = 0;
  logic [SEG_W-1:0] tmpl_wseg = '0;
  logic [TSEG_W-1:0] tmpl_wval = '0;
  logic thread_mode = 0, thread_done = 0;
  logic tok_valid = 0, tok_ready, tok_first = 0;
  logic [DATA_W-1:0] tok_data = '0;
  logic [SEG_W-1:0] tok_seg = '0;
  logic [DISP_W-1:0] tok_disp = '0;
  logic [1:0] tok_flag = 2'b00;
  logic fire_valid, fire_ready = 1;
  logic [TSEG_W+DISP_W-1:0] fire_addr;
  logic [DATA_W-1:0] fire_left, fire_right;
  logic [1:0] fire_flag;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dm_sync_unit #(.DATA_W(DATA_W), .SEG_W(SEG_W), .DISP_W(DISP_W),
                 .TSEG_W(TSEG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tmpl_we(tmpl_we), .tmpl_wseg(tmpl_wseg),
    .tmpl_wval(tmpl_wval), .thread_mode(thread_mode),
    .thread_done(thread_done), .tok_valid(tok_valid), .tok_ready(tok_ready),
    .tok_data(tok_data), .tok_seg(tok_seg), .tok_disp(tok_disp),
    .tok_flag(tok_flag), .tok_first(tok_first), .fire_valid(fire_valid),
    .fire_ready(fire_ready), .fire_addr(fire_addr), .fire_left(fire_left),
    .fire_right(fire_right), .fire_flag(fire_flag)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int n = 0; n < 1000 && !tok_ready; n++) @(negedge clk);
  endtask

  // Drives one token; returns at the negedge after the accepting edge.
  task automatic send(input logic [1:0] f, input logic [SEG_W-1:0] s,
                      input logic [DISP_W-1:0] d, input logic [DATA_W-1:0] v,
                      input logic first);
    @(negedge clk);
    tok_flag = f; tok_seg = s; tok_disp = d; tok_data = v;
    tok_first = first; tok_valid = 1;
    wait_ready();
    @(negedge clk);
    tok_valid = 0; tok_first = 0;
  endtask

  task automatic expect_fire(input string req, input int addr,
                             input int l, input int r, input int f);
    chk({req, " valid"}, 32'(fire_valid), 1);
    chk({req, " addr"}, 32'(fire_addr), 32'(addr));
    chk({req, " left"}, 32'(fire_left), 32'(l));
    chk({req, " right"}, 32'(fire_right), 32'(r));
    chk({req, " flag"}, 32'(fire_flag), 32'(f));
  endtask

  task automatic t_reset();
    int cyc = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R1 ready low", 32'(tok_ready), 0);
    chk("R1 fire low", 32'(fire_valid), 0);
    while (!tok_ready && cyc < 1000) begin @(negedge clk); cyc++; end
    chk("R1 sweep length", 32'(cyc >= SLOTS), 1);
    chk("R1 ready rises", 32'(tok_ready), 1);
  endtask

  task automatic t_mono_imm();
    send(2'b00, 0, 4, 16'h1234, 0);
    expect_fire("R2 mono", 4, 16'h1234, 0, 2'b00);
    // R3: immediate between two halves of a pair leaves the slot alone
    send(2'b01, 0, 9, 16'hAAAA, 0);
    chk("R3 store", 32'(fire_valid), 0);
    send(2'b11, 0, 9, 16'h5555, 0);
    expect_fire("R3 imm", 9, 16'h5555, 0, 2'b11);
    send(2'b10, 0, 9, 16'hBBBB, 0);
    expect_fire("R3 untouched", 9, 16'hAAAA, 16'hBBBB, 2'b10);
  endtask

  task automatic t_template();
    @(negedge clk);
    tmpl_we = 1; tmpl_wseg = 2; tmpl_wval = 5;
    @(negedge clk);
    tmpl_we = 0;
    send(2'b00, 2, 3, 16'h0042, 0);
    expect_fire("R4 addr", 5 * 16 + 3, 16'h0042, 0, 2'b00);
  endtask

  task automatic t_pairs();
    send(2'b01, 0, 1, 16'h00A1, 0);
    chk("R5 first stores", 32'(fire_valid), 0);
    send(2'b10, 0, 1, 16'h00B1, 0);
    expect_fire("R6 left then right", 1, 16'h00A1, 16'h00B1, 2'b10);
    send(2'b10, 0, 2, 16'h00C2, 0);
    chk("R5 right stores", 32'(fire_valid), 0);
    send(2'b01, 0, 2, 16'h00D2, 0);
    expect_fire("R6 right then left", 2, 16'h00D2, 16'h00C2, 2'b01);
    send(2'b01, 0, 1, 16'h00E1, 0);
    chk("R7 bit cleared", 32'(fire_valid), 0);
    send(2'b10, 0, 1, 16'h00F1, 0);
    expect_fire("R7 rematch", 1, 16'h00E1, 16'h00F1, 2'b10);
    send(2'b01, 0, 5, 16'h0105, 0);
    send(2'b10, 1, 5, 16'h0115, 0);
    chk("R7 seg isolation", 32'(fire_valid), 0);
    send(2'b10, 0, 5, 16'h0125, 0);
    expect_fire("R7 own seg", 5, 16'h0105, 16'h0125, 2'b10);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    tok_flag = 2'b01; tok_seg = 3; tok_disp = 7; tok_data = 16'h0701;
    tok_valid = 1;
    wait_ready();
    @(negedge clk);
    chk("R8 first stored", 32'(fire_valid), 0);
    tok_flag = 2'b10; tok_data = 16'h0702;
    @(negedge clk);
    tok_valid = 0;
    expect_fire("R8 back to back", 7, 16'h0701, 16'h0702, 2'b10);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    fire_ready = 0;
    send(2'b00, 0, 6, 16'h0606, 0);
    expect_fire("R9 held", 6, 16'h0606, 0, 2'b00);
    chk("R9 ready low", 32'(tok_ready), 0);
    repeat (3) @(negedge clk);
    expect_fire("R9 still held", 6, 16'h0606, 0, 2'b00);
    chk("R9 ready still low", 32'(tok_ready), 0);
    fire_ready = 1;
    @(negedge clk);
    chk("R9 drained", 32'(fire_valid), 0);
    chk("R9 ready back", 32'(tok_ready), 1);
  endtask

  task automatic t_thread();
    send(2'b00, 0, 8, 16'h0808, 1);
    chk("R10 no lock when mode off", 32'(tok_ready), 1);
    thread_mode = 1;
    send(2'b00, 0, 8, 16'h0809, 1);
    expect_fire("R10 first fires", 8, 16'h0809, 0, 2'b00);
    chk("R10 locked", 32'(tok_ready), 0);
    repeat (4) @(negedge clk);
    chk("R10 stays locked", 32'(tok_ready), 0);
    thread_done = 1;
    @(negedge clk);
    thread_done = 0;
    chk("R10 released", 32'(tok_ready), 1);
    send(2'b00, 0, 8, 16'h080A, 0);
    expect_fire("R10 accepts after release", 8, 16'h080A, 0, 2'b00);
    chk("R10 no relock", 32'(tok_ready), 1);
    thread_mode = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_mono_imm();
    t_template();
    t_pairs();
    t_back_to_back();
    t_backpressure();
    t_thread();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule